// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block switches a small set of power domains on and off in a fixed, safe order. Every domain owns bits in three shared control registers. In the power-down register a set bit removes power. In the isolation register a cleared bit clamps the domain's outputs, so it is active-low. In the 32-bit unit reset register a cleared bit holds a unit in reset, so it is also active-low. Each domain has a one-cycle up request and a one-cycle down request. For every domain the block runs a small state machine that walks the three register changes in order. A programmable number of idle cycles separates consecutive changes.

The bit masks of each domain are parameters. A step whose mask is zero is skipped. Changes requested by different domains in the same cycle are granted one at a time, so no read-modify-write update loses another domain's bits. A small register port gives software direct read and write access to all three registers and the gap setting. It also provides a pulse command that drops chosen unit reset bits for exactly one cycle. The block reports per-domain on/off status and a per-domain busy flag.

Per-domain states: IDLE (no sequence); UP_PWR, UP_RST and UP_ISO (the three power-up steps); DN_ISO, DN_RST and DN_PWR (the three power-down steps); GAP (counting the delay between steps). The transitions are:
- IDLE to UP_PWR on an up request.
- IDLE to DN_ISO on a down request. A down request wins over an up request in the same cycle.
- A step state moves to GAP when it is granted, or to the following step state when its mask is zero.
- GAP moves to the stored following step when its counter reaches zero.
- UP_ISO and DN_PWR return to IDLE when they are granted or skipped.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the outputs hold these values: power-down register 0x0000_0004, isolation register 0xFFFF_FFFD, unit reset register 0xFFFF_FFFF, gap 1, busy all zero. Each domain's dom_on bit is 1 exactly when its power-down mask bits are clear in the reset value, which gives dom_on = 3'b101 by default. Default masks, given as power-down / reset / isolation: domain 0 is 0x8 / 0x0001_0000 / 0x1, domain 1 is 0x4 / 0 / 0x2, domain 2 is 0x1 / 0x0004_0000 / 0.
- R2: A power-up sequence clears the domain's power-down bits, then sets its reset bits, then sets its isolation bits.
- R3: A power-down sequence clears the domain's isolation bits, then clears its reset bits, then sets its power-down bits.
- R4: A step whose mask is zero changes no register and takes one cycle with no gap after it. Two granted steps with no skipped step between them are gap+2 cycles apart. With one skipped step between them they are gap+3 cycles apart.
- R5: dom_busy rises on the clock edge that accepts a request. dom_busy falls and dom_on takes its new value (1 for up, 0 for down) on the edge that completes or skips the last step.
- R6: An up or down request for a domain whose dom_busy is high is ignored.
- R7: When several domains request a step in the same cycle, only the lowest-numbered domain is granted. The others wait, and no domain's register bits are lost.
- R8: reg_addr selects 0 = power-down, 1 = isolation, 2 = unit reset, 3 = gap (low 8 bits) and 4 = pulse. reg_rdata returns the selected register, and 0 for codes 4 to 7. A write replaces the register at the next edge. A write cycle grants no sequencer step, so a pending step is delayed by one cycle.
- R9: A write to code 4 clears the unit reset bits that are set in the data for exactly one cycle, then sets them again. No sequencer step is granted in the cycle where the bits are set again.
- R10: Up and down requests for the same idle domain in the same cycle start a power-down sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | NUM_DOM | Per-domain power-up request, one cycle |
| dn_req | input | NUM_DOM | Per-domain power-down request, one cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select code |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the selected register |
| pd_ctrl | output | REG_W | Power-down register, 1 = unpowered |
| iso_ctrl_n | output | REG_W | Isolation register, 0 = clamped |
| unit_rst_n | output | REG_W | Unit reset register, 0 = in reset |
| dom_on | output | NUM_DOM | Per-domain on status |
| dom_busy | output | NUM_DOM | Per-domain sequence in progress |

## Verification
A wrong step order, a lost grant or a miscounted gap shows at the three register outputs within a few cycles. A lost or reordered grant shifts a bit change by one or more edges. A corrupt read-modify-write clears a bit that belongs to another domain. Because the bench model is compared at every clock, such a fault is reported in the first cycle where a register, dom_busy or dom_on differs from the model. Directed checks also measure the cycle distances between the steps of a sequence.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UP_PWR,
        ST_UP_RST,
        ST_UP_ISO,
        ST_DN_ISO,
        ST_DN_RST,
        ST_DN_PWR,
        ST_GAP
    } seq_state_e;

    typedef enum logic [2:0] {
        K_PWR_CLR,
        K_PWR_SET,
        K_RST_REL,
        K_RST_HOLD,
        K_ISO_REL,
        K_ISO_ENG
    } step_kind_e;

    localparam logic [2:0] A_PWR   = 3'd0;
    localparam logic [2:0] A_ISO   = 3'd1;
    localparam logic [2:0] A_RST   = 3'd2;
    localparam logic [2:0] A_GAP   = 3'd3;
    localparam logic [2:0] A_PULSE = 3'd4;

endpackage

// File: rtl/pwr_seq_dom.sv
`timescale 1ns/1ps
module pwr_seq_dom
    import pwr_seq_pkg::*;
#(
    parameter int              REG_W    = 32,
    parameter int              GAP_W    = 8,
    parameter logic [REG_W-1:0] PWR_MASK = '0,
    parameter logic [REG_W-1:0] RST_MASK = '0,
    parameter logic [REG_W-1:0] ISO_MASK = '0,
    parameter bit              INIT_ON  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_req,
    input  logic             dn_req,
    input  logic             grant,
    input  logic [GAP_W-1:0] gap_cfg,
    output logic             step_req,
    output step_kind_e       step_kind,
    output logic [REG_W-1:0] step_mask,
    output logic             busy,
    output logic             is_on
);

    seq_state_e       state_q, state_d, ret_q, ret_d;
    logic [GAP_W-1:0] cnt_q, cnt_d;
    logic             on_q, on_d, up_q, up_d;
    logic             in_step;

    function automatic seq_state_e follow(input seq_state_e s);
        case (s)
            ST_UP_PWR: return ST_UP_RST;
            ST_UP_RST: return ST_UP_ISO;
            ST_DN_ISO: return ST_DN_RST;
            ST_DN_RST: return ST_DN_PWR;
            default:   return ST_IDLE;
        endcase
    endfunction

    function automatic step_kind_e kind_of(input seq_state_e s);
        case (s)
            ST_UP_PWR: return K_PWR_CLR;
            ST_UP_RST: return K_RST_REL;
            ST_UP_ISO: return K_ISO_REL;
            ST_DN_ISO: return K_ISO_ENG;
            ST_DN_RST: return K_RST_HOLD;
            default:   return K_PWR_SET;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] mask_of(input seq_state_e s);
        case (s)
            ST_UP_PWR, ST_DN_PWR: return PWR_MASK;
            ST_UP_RST, ST_DN_RST: return RST_MASK;
            ST_UP_ISO, ST_DN_ISO: return ISO_MASK;
            default:              return '0;
        endcase
    endfunction

    // output process: step request towards the arbiter
    always_comb begin
        in_step   = (state_q != ST_IDLE) && (state_q != ST_GAP);
        step_kind = kind_of(state_q);
        step_mask = in_step ? mask_of(state_q) : '0;
        step_req  = in_step && (step_mask != '0);
        busy      = (state_q != ST_IDLE);
        is_on     = on_q;
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        cnt_d   = cnt_q;
        on_d    = on_q;
        up_d    = up_q;
        unique case (state_q)
            ST_IDLE: begin
                if (dn_req) begin
                    up_d    = 1'b0;
                    state_d = ST_DN_ISO;
                end else if (up_req) begin
                    up_d    = 1'b1;
                    state_d = ST_UP_PWR;
                end
            end
            ST_GAP: begin
                if (cnt_q == '0) state_d = ret_q;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: begin
                if (!step_req) begin
                    state_d = follow(state_q);
                end else if (grant) begin
                    if (follow(state_q) == ST_IDLE) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_GAP;
                        ret_d   = follow(state_q);
                        cnt_d   = gap_cfg;
                    end
                end
                if (state_d == ST_IDLE) on_d = up_q;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= ST_IDLE;
            cnt_q   <= '0;
            on_q    <= INIT_ON;
            up_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            cnt_q   <= cnt_d;
            on_q    <= on_d;
            up_q    <= up_d;
        end
    end

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && (up_req || dn_req)) |=> busy);

    // R5
    done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (is_on == $past(up_q)));

    // R6
    dir_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(up_q));

    // R4
    skip_nogap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_step && step_mask == '0) |=> (state_q != ST_GAP));

endmodule

// File: rtl/pwr_seq_arb.sv
`timescale 1ns/1ps
module pwr_seq_arb #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         hold,
    output logic [N-1:0] grant
);

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    // fixed priority: the lowest index wins
    always_comb begin
        grant = '0;
        if (!hold) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (req[i]) grant = ONE << i;
            end
        end
    end

    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7
    grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((req & (grant - ONE)) == '0));

    // R8
    hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (grant == '0));

endmodule

// File: rtl/pwr_seq_regs.sv
`timescale 1ns/1ps
module pwr_seq_regs
    import pwr_seq_pkg::*;
#(
    parameter int               REG_W    = 32,
    parameter int               GAP_W    = 8,
    parameter logic [REG_W-1:0] PWR_INIT = '0,
    parameter logic [REG_W-1:0] ISO_INIT = '1,
    parameter logic [REG_W-1:0] RST_INIT = '1,
    parameter logic [GAP_W-1:0] GAP_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [2:0]       sw_addr,
    input  logic [REG_W-1:0] sw_wdata,
    output logic [REG_W-1:0] sw_rdata,
    input  logic             step_vld,
    input  step_kind_e       step_kind,
    input  logic [REG_W-1:0] step_mask,
    output logic             hold,
    output logic [GAP_W-1:0] gap_cfg,
    output logic [REG_W-1:0] pd_o,
    output logic [REG_W-1:0] iso_o,
    output logic [REG_W-1:0] urst_o
);

    logic [REG_W-1:0] pwr_q, pwr_d, iso_q, iso_d, urst_q, urst_d, pend_q, pend_d;
    logic [GAP_W-1:0] gap_q, gap_d;

    assign hold = sw_we || (pend_q != '0);

    always_comb begin
        pwr_d  = pwr_q;
        iso_d  = iso_q;
        urst_d = urst_q | pend_q;
        gap_d  = gap_q;
        pend_d = '0;
        if (sw_we) begin
            case (sw_addr)
                A_PWR:   pwr_d  = sw_wdata;
                A_ISO:   iso_d  = sw_wdata;
                A_RST:   urst_d = sw_wdata;
                A_GAP:   gap_d  = sw_wdata[GAP_W-1:0];
                A_PULSE: begin
                    urst_d = urst_d & ~sw_wdata;
                    pend_d = sw_wdata;
                end
                default: ;
            endcase
        end else if (step_vld) begin
            case (step_kind)
                K_PWR_CLR:  pwr_d  = pwr_q & ~step_mask;
                K_PWR_SET:  pwr_d  = pwr_q | step_mask;
                K_RST_REL:  urst_d = urst_q | step_mask;
                K_RST_HOLD: urst_d = urst_q & ~step_mask;
                K_ISO_REL:  iso_d  = iso_q | step_mask;
                K_ISO_ENG:  iso_d  = iso_q & ~step_mask;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q  <= PWR_INIT;
            iso_q  <= ISO_INIT;
            urst_q <= RST_INIT;
            gap_q  <= GAP_INIT;
            pend_q <= '0;
        end else begin
            pwr_q  <= pwr_d;
            iso_q  <= iso_d;
            urst_q <= urst_d;
            gap_q  <= gap_d;
            pend_q <= pend_d;
        end
    end

    always_comb begin
        case (sw_addr)
            A_PWR:   sw_rdata = pwr_q;
            A_ISO:   sw_rdata = iso_q;
            A_RST:   sw_rdata = urst_q;
            A_GAP:   sw_rdata = {{(REG_W-GAP_W){1'b0}}, gap_q};
            default: sw_rdata = '0;
        endcase
    end

    assign gap_cfg = gap_q;
    assign pd_o    = pwr_q;
    assign iso_o   = iso_q;
    assign urst_o  = urst_q;

    // R8
    sw_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |-> !step_vld);

    // R2
    pwr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_vld && step_kind == K_PWR_CLR) |=> ((pd_o & $past(step_mask)) == '0));

    // R3
    pwr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_vld && step_kind == K_PWR_SET) |=> ((pd_o & $past(step_mask)) == $past(step_mask)));

    // R9
    pulse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && sw_addr == A_PULSE) |=> ((urst_o & $past(sw_wdata)) == '0));

    // R9
    pulse_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0 && !sw_we) |=> ((urst_o & $past(pend_q)) == $past(pend_q)));

endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int NUM_DOM = 3,
    parameter int REG_W   = 32,
    parameter int GAP_W   = 8,
    parameter logic [NUM_DOM-1:0][REG_W-1:0] DOM_PWR_MASK = {32'h0000_0001, 32'h0000_0004, 32'h0000_0008},
    parameter logic [NUM_DOM-1:0][REG_W-1:0] DOM_RST_MASK = {32'h0004_0000, 32'h0000_0000, 32'h0001_0000},
    parameter logic [NUM_DOM-1:0][REG_W-1:0] DOM_ISO_MASK = {32'h0000_0000, 32'h0000_0002, 32'h0000_0001},
    parameter logic [REG_W-1:0] PWR_INIT = 32'h0000_0004,
    parameter logic [REG_W-1:0] ISO_INIT = 32'hFFFF_FFFD,
    parameter logic [REG_W-1:0] RST_INIT = 32'hFFFF_FFFF,
    parameter logic [GAP_W-1:0] GAP_INIT = 8'd1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DOM-1:0] up_req,
    input  logic [NUM_DOM-1:0] dn_req,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic [REG_W-1:0]   pd_ctrl,
    output logic [REG_W-1:0]   iso_ctrl_n,
    output logic [REG_W-1:0]   unit_rst_n,
    output logic [NUM_DOM-1:0] dom_on,
    output logic [NUM_DOM-1:0] dom_busy
);

    logic [NUM_DOM-1:0] step_req, grant;
    step_kind_e         kind_a [NUM_DOM];
    logic [REG_W-1:0]   mask_a [NUM_DOM];
    logic               hold, sel_vld;
    step_kind_e         sel_kind;
    logic [REG_W-1:0]   sel_mask;
    logic [GAP_W-1:0]   gap_cfg;

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        pwr_seq_dom #(
            .REG_W    (REG_W),
            .GAP_W    (GAP_W),
            .PWR_MASK (DOM_PWR_MASK[d]),
            .RST_MASK (DOM_RST_MASK[d]),
            .ISO_MASK (DOM_ISO_MASK[d]),
            .INIT_ON  ((PWR_INIT & DOM_PWR_MASK[d]) == '0)
        ) u_dom (
            .clk       (clk),
            .rst_n     (rst_n),
            .up_req    (up_req[d]),
            .dn_req    (dn_req[d]),
            .grant     (grant[d]),
            .gap_cfg   (gap_cfg),
            .step_req  (step_req[d]),
            .step_kind (kind_a[d]),
            .step_mask (mask_a[d]),
            .busy      (dom_busy[d]),
            .is_on     (dom_on[d])
        );
    end

    pwr_seq_arb #(.N(NUM_DOM)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (step_req),
        .hold  (hold),
        .grant (grant)
    );

    always_comb begin
        sel_vld  = |grant;
        sel_kind = K_PWR_CLR;
        sel_mask = '0;
        for (int d = 0; d < NUM_DOM; d++) begin
            if (grant[d]) begin
                sel_kind = kind_a[d];
                sel_mask = mask_a[d];
            end
        end
    end

    pwr_seq_regs #(
        .REG_W    (REG_W),
        .GAP_W    (GAP_W),
        .PWR_INIT (PWR_INIT),
        .ISO_INIT (ISO_INIT),
        .RST_INIT (RST_INIT),
        .GAP_INIT (GAP_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_we     (reg_we),
        .sw_addr   (reg_addr),
        .sw_wdata  (reg_wdata),
        .sw_rdata  (reg_rdata),
        .step_vld  (sel_vld),
        .step_kind (sel_kind),
        .step_mask (sel_mask),
        .hold      (hold),
        .gap_cfg   (gap_cfg),
        .pd_o      (pd_ctrl),
        .iso_o     (iso_ctrl_n),
        .urst_o    (unit_rst_n)
    );

    // R7
    busy_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~dom_busy) == '0));

endmodule

// File: tb/pwr_seq_ctrl_test.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_test;

    localparam int ND = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [ND-1:0] up_req = '0, dn_req = '0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata, pd_ctrl, iso_ctrl_n, unit_rst_n;
    logic [ND-1:0] dom_on, dom_busy;

    int    errors = 0, checks = 0, cyc = 0;
    string cur_req = "R1";
    bit    run = 1'b0;

    always #2.5 clk = ~clk;

    pwr_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .dn_req(dn_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pd_ctrl(pd_ctrl), .iso_ctrl_n(iso_ctrl_n),
        .unit_rst_n(unit_rst_n), .dom_on(dom_on), .dom_busy(dom_busy)
    );

    // per-domain masks from R1
    function automatic logic [31:0] pmask(int d);
        case (d) 0: return 32'h8; 1: return 32'h4; default: return 32'h1; endcase
    endfunction
    function automatic logic [31:0] rmask(int d);
        case (d) 0: return 32'h0001_0000; 1: return 32'h0; default: return 32'h0004_0000; endcase
    endfunction
    function automatic logic [31:0] imask(int d);
        case (d) 0: return 32'h1; 1: return 32'h2; default: return 32'h0; endcase
    endfunction
    // mask of step p (0..2) of a sequence, per R2 and R3
    function automatic logic [31:0] smask(int d, bit u, int p);
        if (p == 1) return rmask(d);
        if ((p == 0) == u) return pmask(d);
        return imask(d);
    endfunction

    // behavioural reference model
    logic [31:0] m_pwr, m_iso, m_rst, m_pend;
    int          m_gap;
    int          ph [ND];
    int          pos [ND];
    int          cnt [ND];
    bit          up [ND];
    bit          mon [ND];

    task automatic model_reset();
        m_pwr = 32'h4; m_iso = 32'hFFFF_FFFD; m_rst = 32'hFFFF_FFFF; m_pend = 0; m_gap = 1;
        for (int d = 0; d < ND; d++) begin
            ph[d] = 0; pos[d] = 0; cnt[d] = 0; up[d] = 0;
            mon[d] = ((32'h4 & pmask(d)) == 0);
        end
    endtask

    task automatic model_step();
        bit          hold = reg_we || (m_pend != 0);
        int          g = -1;
        logic [31:0] npwr = m_pwr, niso = m_iso, nrst = m_rst | m_pend, npend = 0, mk;
        int          ngap = m_gap;
        for (int d = 0; d < ND; d++)
            if (g < 0 && !hold && ph[d] == 1 && smask(d, up[d], pos[d]) != 0) g = d;
        if (reg_we) begin
            case (reg_addr)
                3'd0: npwr = reg_wdata;
                3'd1: niso = reg_wdata;
                3'd2: nrst = reg_wdata;
                3'd3: ngap = int'(reg_wdata[7:0]);
                3'd4: begin nrst = nrst & ~reg_wdata; npend = reg_wdata; end
                default: ;
            endcase
        end else if (g >= 0) begin
            mk = smask(g, up[g], pos[g]);
            if (up[g]) begin
                if (pos[g] == 0) npwr = npwr & ~mk;
                else if (pos[g] == 1) nrst = nrst | mk;
                else niso = niso | mk;
            end else begin
                if (pos[g] == 0) niso = niso & ~mk;
                else if (pos[g] == 1) nrst = nrst & ~mk;
                else npwr = npwr | mk;
            end
        end
        for (int d = 0; d < ND; d++) begin
            if (ph[d] == 0) begin
                if (dn_req[d]) begin up[d] = 0; pos[d] = 0; ph[d] = 1; end
                else if (up_req[d]) begin up[d] = 1; pos[d] = 0; ph[d] = 1; end
            end else if (ph[d] == 1) begin
                if (smask(d, up[d], pos[d]) == 0 || d == g) begin
                    if (pos[d] == 2) begin ph[d] = 0; mon[d] = up[d]; end
                    else begin
                        pos[d]++;
                        if (d == g) begin ph[d] = 2; cnt[d] = m_gap; end
                    end
                end
            end else begin
                if (cnt[d] == 0) ph[d] = 1; else cnt[d]--;
            end
        end
        m_pwr = npwr; m_iso = niso; m_rst = nrst; m_pend = npend; m_gap = ngap;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) model_reset(); else model_step();
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && run) begin
            logic [31:0]   erd;
            logic [ND-1:0] eon, ebusy;
            case (reg_addr)
                3'd0: erd = m_pwr; 3'd1: erd = m_iso; 3'd2: erd = m_rst;
                3'd3: erd = 32'(m_gap); default: erd = 0;
            endcase
            for (int d = 0; d < ND; d++) begin eon[d] = mon[d]; ebusy[d] = (ph[d] != 0); end
            checks++;
            if ({pd_ctrl, iso_ctrl_n, unit_rst_n, reg_rdata, dom_on, dom_busy} !==
                {m_pwr, m_iso, m_rst, erd, eon, ebusy}) begin
                errors++;
                $display("FAIL %s cycle %0d: got pd=%h iso=%h rst=%h rd=%h on=%b busy=%b exp pd=%h iso=%h rst=%h rd=%h on=%b busy=%b",
                         cur_req, cyc, pd_ctrl, iso_ctrl_n, unit_rst_n, reg_rdata, dom_on, dom_busy,
                         m_pwr, m_iso, m_rst, erd, eon, ebusy);
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (dom_busy != 0 && guard < 200) begin tick(1); guard++; end
    endtask

    // watchdog
    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: run did not end");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int t0, t1, t2;
        tick(3);
        rst_n = 1'b1;
        run = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 pd", pd_ctrl, 32'h4);
        chk("R1 iso", iso_ctrl_n, 32'hFFFF_FFFD);
        chk("R1 rst", unit_rst_n, 32'hFFFF_FFFF);
        chk("R1 on", 32'(dom_on), 32'b101);
        chk("R1 busy", 32'(dom_busy), 0);

        // R8 register access
        cur_req = "R8";
        wr(3'd3, 32'h0000_0102);
        chk("R8 gap readback", reg_rdata, 32'h2);
        wr(3'd0, 32'h0000_0104);
        reg_addr = 3'd0; #0.5;
        chk("R8 pd readback", reg_rdata, 32'h104);
        wr(3'd0, 32'h0000_0004);
        reg_addr = 3'd5; #0.5;
        chk("R8 unused code reads zero", reg_rdata, 0);

        // R2 and R4: domain 1 up, its reset step is skipped
        cur_req = "R2";
        up_req[1] = 1'b1; tick(1); up_req[1] = 1'b0;
        chk("R5 busy after request", 32'(dom_busy), 32'b010);
        t0 = -1; t1 = -1;
        for (int k = 0; k < 40 && dom_busy[1]; k++) begin
            tick(1);
            if (t0 < 0 && pd_ctrl[2] == 1'b0) t0 = cyc;
            if (t1 < 0 && iso_ctrl_n[1] == 1'b1) t1 = cyc;
        end
        chk("R4 skip distance", 32'(t1 - t0), 32'd5);
        chk("R2 pd", pd_ctrl, 32'h0);
        chk("R4 rst untouched", unit_rst_n, 32'hFFFF_FFFF);
        chk("R5 on after up", 32'(dom_on), 32'b111);

        // R3 and R6: domain 0 down, an up request during it is ignored
        cur_req = "R3";
        dn_req[0] = 1'b1; tick(1); dn_req[0] = 1'b0;
        t0 = -1; t1 = -1; t2 = -1;
        for (int k = 0; k < 40 && dom_busy[0]; k++) begin
            if (k == 2) begin cur_req = "R6"; up_req[0] = 1'b1; end
            tick(1);
            up_req[0] = 1'b0;
            if (t0 < 0 && iso_ctrl_n[0] == 1'b0) t0 = cyc;
            if (t1 < 0 && unit_rst_n[16] == 1'b0) t1 = cyc;
            if (t2 < 0 && pd_ctrl[3] == 1'b1) t2 = cyc;
        end
        chk("R3 iso to rst distance", 32'(t1 - t0), 32'd4);
        chk("R3 rst to pd distance", 32'(t2 - t1), 32'd4);
        tick(2);
        chk("R6 no restart", 32'(dom_busy), 0);
        chk("R6 stays off", 32'(dom_on), 32'b110);

        // R7: domain 2 down and domain 0 up contend in one cycle
        cur_req = "R7";
        dn_req[2] = 1'b1; tick(1); dn_req[2] = 1'b0;
        up_req[0] = 1'b1; tick(1); up_req[0] = 1'b0;
        t0 = -1; t1 = -1;
        for (int k = 0; k < 60 && dom_busy != 0; k++) begin
            tick(1);
            if (t0 < 0 && pd_ctrl[3] == 1'b0) t0 = cyc;
            if (t1 < 0 && unit_rst_n[18] == 1'b0) t1 = cyc;
        end
        chk("R7 lower index first", 32'(t1 - t0), 32'd1);
        chk("R7 pd merged", pd_ctrl, 32'h1);
        chk("R7 rst merged", unit_rst_n, 32'hFFFB_FFFF);
        chk("R7 iso merged", iso_ctrl_n, 32'hFFFF_FFFF);
        chk("R7 on", 32'(dom_on), 32'b011);

        // R9 reset pulse
        cur_req = "R9";
        wr(3'd4, 32'h0000_0F00);
        chk("R9 bits low", unit_rst_n & 32'h0F00, 0);
        tick(1);
        chk("R9 bits high again", unit_rst_n & 32'h0F00, 32'h0F00);

        // R8: a write in the request cycle delays domain 1's first step
        cur_req = "R8";
        dn_req[1] = 1'b1; tick(1); dn_req[1] = 1'b0;
        wr(3'd3, 32'h2);
        chk("R8 step stalled", 32'(iso_ctrl_n[1]), 1);
        tick(1);
        chk("R8 step after write", 32'(iso_ctrl_n[1]), 0);
        wait_idle();

        // R10: simultaneous requests on idle domain 2 start power-down
        cur_req = "R10";
        up_req[2] = 1'b1; dn_req[2] = 1'b1; tick(1);
        up_req[2] = 1'b0; dn_req[2] = 1'b0;
        wait_idle();
        chk("R10 pd kept", 32'(pd_ctrl[0]), 1);
        chk("R10 still off", 32'(dom_on[2]), 0);

        tick(2);
        run = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule